// File: doc/BRIEF.md
# Datapath Function Unit with Shifter

This block is the combinational arithmetic, logic and shift engine of a simple register datapath. Two n-bit operands, A and B, enter together with a 4-bit function-select code. The unit returns one n-bit result and four status flags. Nothing in it is clocked. A register file ahead of it supplies the operands, and the result goes back onto a destination bus in the same cycle.

Inside, an adder adds A, a B-derived second operand (zeros, B, inverted B or ones) and a carry-in. A bitwise logic stage works on A and B. A one-position shifter works on B alone and fills the vacated bit with zero. The low code bit is shared: it is the adder carry-in and also a logic select. When the top two code bits are both set, the output multiplexer takes the shifter instead of the arithmetic/logic result. The flags always describe the arithmetic/logic result, even when the shifter drives F.

Top module: `func_unit`

## Requirements
- R1: For codes with FS[3]=0, F = (A + Y + FS[0]) mod 2^n. Y is selected by FS[2:1]: 00 all zeros, 01 B, 10 bitwise NOT B, 11 all ones. So 0000 passes A, 0001 is A+1, 0010 is A+B, 0011 is A+B+1, 0100 is A+~B, 0101 is A−B, 0110 is A−1 and 0111 passes A.
- R2: For codes with FS[3]=0, C is the carry out of the most significant bit of that addition.
- R3: For codes with FS[3]=0, V is 1 exactly when the addition overflows as a two's complement operation, that is when the carry into the MSB differs from the carry out of it.
- R4: Code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R5: Codes 1100 and 1111 both give F = B.
- R6: Code 1101 shifts B right by one place, and a zero enters the MSB. Code 1110 shifts B left by one place, and a zero enters bit 0.
- R7: When FS[3]=1, V and C are both 0.
- R8: N is the MSB of the arithmetic/logic result. For codes 11xx that result is the logic operation picked by FS[1:0] (00 AND, 01 OR, 10 XOR, 11 NOT A), not the shifter output.
- R9: Z is 1 exactly when the arithmetic/logic result (as defined in R8) is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B, also the shifter input |
| fs | input | 4 | Function-select code |
| f | output | WIDTH | Selected result |
| v | output | 1 | Overflow flag |
| c | output | 1 | Carry flag |
| n | output | 1 | Negative flag (MSB of arithmetic/logic result) |
| z | output | 1 | Zero flag (arithmetic/logic result is zero) |

## Verification
For the shift and pass-B codes, the shifter drives F while the logic stage still computes a result that sets N and Z. The two functions are therefore active in the same evaluation and can disagree. The bench provokes this with operand pairs where the shifted B and the logic result of A and B differ in MSB and in zeroness. One example is B = 0 with A nonzero under the OR select. F must then follow the shifter while N and Z follow the logic result. Random vectors over all sixteen codes, with directed carry and overflow boundaries, are compared against a bench model that keeps the two paths separate.

// File: rtl/func_unit_pkg.sv
package func_unit_pkg;

    typedef enum logic [1:0] {
        YSEL_ZERO = 2'b00,
        YSEL_B    = 2'b01,
        YSEL_NOTB = 2'b10,
        YSEL_ONES = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        LOP_AND = 2'b00,
        LOP_OR  = 2'b01,
        LOP_XOR = 2'b10,
        LOP_NOT = 2'b11
    } lop_e;

    typedef enum logic [1:0] {
        SHC_PASS  = 2'b00,
        SHC_RIGHT = 2'b01,
        SHC_LEFT  = 2'b10,
        SHC_SPARE = 2'b11
    } shc_e;

    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flags_t;

    typedef struct packed {
        logic  use_logic;
        logic  use_shift;
        ysel_e ysel;
        logic  cin;
        lop_e  lop;
        shc_e  shc;
    } fsel_t;

    function automatic fsel_t decode_fs(input logic [3:0] code);
        fsel_t d;
        d.use_logic = code[3];
        d.use_shift = code[3] & code[2];
        d.ysel      = ysel_e'(code[2:1]);
        d.cin       = code[0];
        d.lop       = lop_e'(code[1:0]);
        d.shc       = shc_e'(code[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/fu_arith.sv
module fu_arith
    import func_unit_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  ysel_e            ysel,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    logic [WIDTH-1:0] y;
    logic [WIDTH:0]   cy;

    always_comb begin
        case (ysel)
            YSEL_ZERO: y = '0;
            YSEL_B:    y = b;
            YSEL_NOTB: y = ~b;
            default:   y = '1;
        endcase
    end

    assign cy[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]  = a[i] ^ y[i] ^ cy[i];
        assign cy[i+1] = (a[i] & y[i]) | (cy[i] & (a[i] ^ y[i]));
    end

    assign cout = cy[WIDTH];
    assign ovf  = cy[WIDTH] ^ cy[WIDTH-1];

endmodule

// File: rtl/fu_logic.sv
module fu_logic
    import func_unit_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  lop_e             lop,
    output logic [WIDTH-1:0] res
);

    always_comb begin
        case (lop)
            LOP_AND: res = a & b;
            LOP_OR:  res = a | b;
            LOP_XOR: res = a ^ b;
            default: res = ~a;
        endcase
    end

endmodule

// File: rtl/fu_shift.sv
module fu_shift
    import func_unit_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] b,
    input  shc_e             shc,
    input  logic             fill_hi,
    input  logic             fill_lo,
    output logic [WIDTH-1:0] res
);

    always_comb begin
        case (shc)
            SHC_RIGHT: res = {fill_hi, b[WIDTH-1:1]};
            SHC_LEFT:  res = {b[WIDTH-2:0], fill_lo};
            default:   res = b;
        endcase
    end

endmodule

// File: rtl/func_unit.sv
module func_unit
    import func_unit_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       fs,
    output logic [WIDTH-1:0] f,
    output logic             v,
    output logic             c,
    output logic             n,
    output logic             z
);

    localparam int MSB = WIDTH - 1;

    fsel_t            dec;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shift_res;
    logic [WIDTH-1:0] alu_res;
    logic             arith_cout;
    logic             arith_ovf;
    flags_t           flg;

    assign dec = decode_fs(fs);

    fu_arith #(.WIDTH(WIDTH)) u_arith (
        .a    (a),
        .b    (b),
        .ysel (dec.ysel),
        .cin  (dec.cin),
        .sum  (arith_res),
        .cout (arith_cout),
        .ovf  (arith_ovf)
    );

    fu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (a),
        .b   (b),
        .lop (dec.lop),
        .res (logic_res)
    );

    fu_shift #(.WIDTH(WIDTH)) u_shift (
        .b       (b),
        .shc     (dec.shc),
        .fill_hi (1'b0),
        .fill_lo (1'b0),
        .res     (shift_res)
    );

    assign alu_res = dec.use_logic ? logic_res : arith_res;

    always_comb begin
        flg.v = dec.use_logic ? 1'b0 : arith_ovf;
        flg.c = dec.use_logic ? 1'b0 : arith_cout;
        flg.n = alu_res[MSB];
        flg.z = (alu_res == '0);
    end

    assign f = dec.use_shift ? shift_res : alu_res;
    assign v = flg.v;
    assign c = flg.c;
    assign n = flg.n;
    assign z = flg.z;

endmodule

// File: rtl/func_unit_chk.sv
module func_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [3:0]       fs,
    input logic [WIDTH-1:0] f,
    input logic             v,
    input logic             c,
    input logic             n,
    input logic             z
);

    logic known;
    logic [WIDTH:0] wide_ref;
    logic [WIDTH-1:0] y_ref;

    always_comb begin
        known = !$isunknown({a, b, fs, f, v, c, n, z});
        case (fs[2:1])
            2'b00:   y_ref = '0;
            2'b01:   y_ref = b;
            2'b10:   y_ref = ~b;
            default: y_ref = '1;
        endcase
        wide_ref = {1'b0, a} + {1'b0, y_ref} + {{WIDTH{1'b0}}, fs[0]};
    end

    always_comb begin
        if (known) begin
            if (!fs[3]) AST_ARITH_SUM: assert ({c, f} == wide_ref); // R1
            if (fs[3]) AST_LOGIC_NO_FLAGS: assert (!v && !c); // R7
            if (fs == 4'b1100 || fs == 4'b1111) AST_PASS_B: assert (f == b); // R5
            if (fs == 4'b1101) AST_SHR_ZERO_FILL: assert (!f[WIDTH-1] && f[WIDTH-2:0] == b[WIDTH-1:1]); // R6
            if (fs == 4'b1110) AST_SHL_ZERO_FILL: assert (!f[0] && f[WIDTH-1:1] == b[WIDTH-2:0]); // R6
            if (fs[3:2] != 2'b11) AST_NEG_MSB: assert (n == f[WIDTH-1]); // R8
            if (fs[3:2] != 2'b11) AST_ZERO_FLAG: assert (z == (f == '0)); // R9
        end
    end

endmodule

bind func_unit func_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .a  (a),
    .b  (b),
    .fs (fs),
    .f  (f),
    .v  (v),
    .c  (c),
    .n  (n),
    .z  (z)
);

// File: tb/func_unit_test.sv
module func_unit_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   fs = '0;
    logic [W-1:0] f;
    logic         v, c, n, z;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    func_unit #(.WIDTH(W)) uut (
        .a(a), .b(b), .fs(fs), .f(f), .v(v), .c(c), .n(n), .z(z)
    );

    typedef struct packed {
        logic [W-1:0] f;
        logic v, c, n, z;
    } exp_t;

    function automatic exp_t model(input logic [W-1:0] ai, input logic [W-1:0] bi,
                                   input logic [3:0] code);
        exp_t e;
        logic [W-1:0] y, g;
        logic [W:0] s;
        case (code[2:1])
            2'b00: y = '0;
            2'b01: y = bi;
            2'b10: y = ~bi;
            default: y = '1;
        endcase
        s = {1'b0, ai} + {1'b0, y} + {{W{1'b0}}, code[0]};
        if (!code[3]) begin
            g = s[W-1:0];
            e.c = s[W];
            e.v = (ai[W-1] == y[W-1]) && (s[W-1] != ai[W-1]);
        end else begin
            case (code[1:0])
                2'b00: g = ai & bi;
                2'b01: g = ai | bi;
                2'b10: g = ai ^ bi;
                default: g = ~ai;
            endcase
            e.c = 1'b0;
            e.v = 1'b0;
        end
        e.n = g[W-1];
        e.z = (g == '0);
        if (code == 4'b1101)      e.f = {1'b0, bi[W-1:1]};
        else if (code == 4'b1110) e.f = {bi[W-2:0], 1'b0};
        else if (code[3:2] == 2'b11) e.f = bi;
        else e.f = g;
        return e;
    endfunction

    function automatic string f_tag(input logic [3:0] code);
        if (!code[3]) return "R1";
        if (code[2] == 1'b0) return "R4";
        if (code == 4'b1101 || code == 4'b1110) return "R6";
        return "R5";
    endfunction

    task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s fs=%b a=%h b=%h actual=%h expected=%h",
                     tag, what, fs, a, b, act, expv);
        end
    endtask

    task automatic apply(input logic [W-1:0] ai, input logic [W-1:0] bi, input logic [3:0] code);
        exp_t e;
        @(negedge clk);
        a = ai; b = bi; fs = code;
        #5;
        e = model(ai, bi, code);
        chk(f_tag(code), "F", f, e.f);
        chk(code[3] ? "R7" : "R2", "C", {{(W-1){1'b0}}, c}, {{(W-1){1'b0}}, e.c});
        chk(code[3] ? "R7" : "R3", "V", {{(W-1){1'b0}}, v}, {{(W-1){1'b0}}, e.v});
        chk("R8", "N", {{(W-1){1'b0}}, n}, {{(W-1){1'b0}}, e.n});
        chk("R9", "Z", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, e.z});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        // reset state: all inputs zero, code 0000 passes A = 0
        chk("R1", "F after reset", f, '0);
        chk("R9", "Z after reset", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, 1'b1});

        // directed corners
        for (int k = 0; k < 16; k++) apply(16'h8001, 16'h4002, 4'(k));
        apply(16'hFFFF, 16'h0001, 4'b0010);   // R2 carry out, zero result
        apply(16'h7FFF, 16'h0001, 4'b0010);   // R3 positive overflow
        apply(16'h8000, 16'h0001, 4'b0101);   // R3 negative overflow on subtract
        apply(16'h8000, 16'h0000, 4'b0110);   // R3 decrement overflow
        apply(16'h0000, 16'h0000, 4'b0110);   // R2 no carry on 0-1
        apply(16'h1234, 16'h1234, 4'b0101);   // R9 subtract to zero, carry set
        apply(16'h0000, 16'hFFFF, 4'b0111);   // R1 pass A with ones
        apply(16'hFFFF, 16'h8001, 4'b1101);   // R6 right shift zero fill, R8/R9 from OR
        apply(16'h0000, 16'h8001, 4'b1110);   // R6 left shift zero fill, XOR result
        apply(16'h0001, 16'h0000, 4'b1101);   // R9 F zero but OR result nonzero
        apply(16'hFFFF, 16'hF00F, 4'b1111);   // R5 pass B, NOT A is zero
        apply(16'h0000, 16'h0000, 4'b1100);   // R5 pass B zero, AND zero
        apply(16'h5555, 16'hAAAA, 4'b1010);   // R4 XOR all ones

        // constrained random
        seed_dummy = $urandom(32'd20240611);
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (k % 8 == 0) ra = {ra[W-1], {(W-1){ra[0]}}};
            if (k % 8 == 1) rb = {rb[W-1], {(W-1){rb[0]}}};
            apply(ra, rb, 4'($urandom_range(15, 0)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule